// File: doc/BRIEF.md
# Bus Cycle Ready Termination Logic

This block decides the clock edge on which a processor bus cycle may finish. A one-clock start strobe opens a cycle. On that same edge the block captures the accessed region's configuration: a flag that tells it to disregard external ready, and a programmed wait-state count from 0 to 3. The block then counts down the wait states. After that it ends the cycle as soon as a qualified ready is present. When the ignore flag was captured, it ends the cycle as soon as the count expires.

There are two ready sources. The synchronous ready line is sampled directly on the rising clock edge. The asynchronous ready line is registered on a rising edge and then resolved by a second flop on the following falling edge. The resolved value is used on the next rising edge. Either source is enough to end a cycle. The end of a cycle is reported as a single-clock done pulse. Address decoding and the data path sit outside the block.

Top module: `bus_ready_term`

## Requirements
- R1: With ignore mode off, a synchronous ready (`srdy_i` high) sampled on a rising edge, once the wait count has run out, sets `done_o` after that same edge.
- R2: An asynchronous ready (`ardy_i` high) is registered on a rising edge and resolved on the next falling edge. It therefore ends the cycle one rising edge later than a synchronous ready raised at the same time.
- R3: Either ready source alone ends a cycle. When both are raised together, the earlier of the two qualifications wins.
- R4: With ignore mode on (`ign_rdy_i` = 1 at start), `done_o` rises after exactly W+1 rising edges following the start edge, where W is the wait count. Neither ready line has any effect on this timing.
- R5: With ignore mode off, `done_o` never rises before W+1 edges after the start edge, even when ready is already high at the start.
- R6: With ignore mode off and no ready, the cycle stretches one clock at a time with no upper limit. `done_o` stays low.
- R7: `done_o` is high for exactly one clock per cycle.
- R8: A start strobe seen while a cycle is open is ignored. It neither restarts the count nor produces a second done pulse.
- R9: Reset closes any open cycle and clears the synchronizer. `done_o` is low during reset and after it, until a new cycle completes.
- R10: The wait count and the ignore flag are sampled only on the start edge. Changes during a cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge for the control logic, falling edge for async resolution |
| rst_i | input | 1 | Synchronous active-high reset |
| ardy_i | input | 1 | Asynchronous ready, active high |
| srdy_i | input | 1 | Synchronous ready, active high, must meet setup to the rising edge |
| start_i | input | 1 | Cycle-start strobe, one clock |
| ign_rdy_i | input | 1 | Region flag: end the cycle on the wait count alone |
| wait_cnt_i | input | WAIT_W (2) | Programmed wait-state count |
| done_o | output | 1 | Cycle-done pulse, one clock |

## Verification
Count the rising edges after the edge that samples the start strobe. `done_o` is due after edge W+1 in ignore mode. A synchronous ready raised after edge d is first seen on edge d+1, so `done_o` is due after edge max(W+1, d+1). An asynchronous ready raised after edge d takes one extra edge, so `done_o` is due after edge max(W+1, d+2). The bench changes every input just after a rising edge and reads `done_o` one nanosecond after each rising edge. It counts the edge on which the pulse first appears and compares that count with the expected number. It also checks that the pulse is gone on the next edge, and it counts pulses over fixed windows to cover the cases where the cycle must not end.

// File: rtl/brt_pkg.sv
package brt_pkg;
   typedef enum logic {
      BRT_IDLE = 1'b0,
      BRT_WAIT = 1'b1
   } brt_state_e;

   localparam int BRT_MAX_WAIT_W = 4;
endpackage

// File: rtl/brt_ready_sync.sv
module brt_ready_sync #(
   parameter bit HALF_CYCLE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ardy_i,
   output logic ardy_q_o
);
   logic cap_q;
   logic res_q;

   // first stage: capture on the rising edge
   always_ff @(posedge clk_i) begin
      if (rst_i) cap_q <= 1'b0;
      else       cap_q <= ardy_i;
   end

   // second stage: resolve on the falling edge, or a full cycle later
   generate
      if (HALF_CYCLE) begin : g_half
         always_ff @(negedge clk_i) begin
            if (rst_i) res_q <= 1'b0;
            else       res_q <= cap_q;
         end
      end else begin : g_full
         always_ff @(posedge clk_i) begin
            if (rst_i) res_q <= 1'b0;
            else       res_q <= cap_q;
         end
      end
   endgenerate

   assign ardy_q_o = res_q;
endmodule

// File: rtl/brt_wait_timer.sv
module brt_wait_timer #(
   parameter int WAIT_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              load_i,
   input  logic              dec_i,
   input  logic [WAIT_W-1:0] load_val_i,
   output logic              zero_o
);
   localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - ONE;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/brt_cycle_ctrl.sv
module brt_cycle_ctrl
   import brt_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   input  logic ign_rdy_i,
   input  logic srdy_i,
   input  logic ardy_q_i,
   input  logic timer_zero_i,
   output logic load_o,
   output logic dec_o,
   output logic done_o
);
   brt_state_e state_q;
   logic       ign_q;
   logic       done_q;
   logic       rdy_ok;
   logic       finish;

   assign rdy_ok = srdy_i | ardy_q_i;
   assign finish = (state_q == BRT_WAIT) && timer_zero_i && (ign_q || rdy_ok);
   assign load_o = (state_q == BRT_IDLE) && start_i;
   assign dec_o  = (state_q == BRT_WAIT) && !timer_zero_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= BRT_IDLE;
         ign_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         unique case (state_q)
            BRT_IDLE: begin
               if (start_i) begin
                  state_q <= BRT_WAIT;
                  ign_q   <= ign_rdy_i;
               end
            end
            BRT_WAIT: begin
               if (finish) state_q <= BRT_IDLE;
            end
            default: state_q <= BRT_IDLE;
         endcase
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/bus_ready_term.sv
module bus_ready_term #(
   parameter int WAIT_W            = 2,
   parameter bit ASYNC_HALF_CYCLE  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ardy_i,
   input  logic              srdy_i,
   input  logic              start_i,
   input  logic              ign_rdy_i,
   input  logic [WAIT_W-1:0] wait_cnt_i,
   output logic              done_o
);
   generate
      if (WAIT_W < 1 || WAIT_W > brt_pkg::BRT_MAX_WAIT_W) begin : g_bad_width
         $error("bus_ready_term: WAIT_W out of range");
      end
   endgenerate

   logic ardy_q;
   logic timer_zero;
   logic load;
   logic dec;

   brt_ready_sync #(.HALF_CYCLE(ASYNC_HALF_CYCLE)) u_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .ardy_i  (ardy_i),
      .ardy_q_o(ardy_q)
   );

   brt_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .load_i    (load),
      .dec_i     (dec),
      .load_val_i(wait_cnt_i),
      .zero_o    (timer_zero)
   );

   brt_cycle_ctrl u_ctrl (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .start_i     (start_i),
      .ign_rdy_i   (ign_rdy_i),
      .srdy_i      (srdy_i),
      .ardy_q_i    (ardy_q),
      .timer_zero_i(timer_zero),
      .load_o      (load),
      .dec_o       (dec),
      .done_o      (done_o)
   );
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
   parameter int WAIT_W = 2
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              srdy_i,
   input logic              ardy_q_i,
   input logic              start_i,
   input logic              ign_rdy_i,
   input logic [WAIT_W-1:0] wait_cnt_i,
   input logic              done_o
);
   localparam int CNT_W = 8;

   logic             chk_busy;
   logic             chk_ign;
   logic [CNT_W-1:0] chk_cnt;
   logic [CNT_W-1:0] chk_wait;

   // independent shadow of the cycle: edges elapsed since the accepted start
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         chk_busy <= 1'b0;
         chk_ign  <= 1'b0;
         chk_cnt  <= '0;
         chk_wait <= '0;
      end else if ((!chk_busy || done_o) && start_i) begin
         chk_busy <= 1'b1;
         chk_ign  <= ign_rdy_i;
         chk_cnt  <= '0;
         chk_wait <= CNT_W'(wait_cnt_i);
      end else if (chk_busy && done_o) begin
         chk_busy <= 1'b0;
      end else if (chk_busy && chk_cnt != '1) begin
         chk_cnt <= chk_cnt + 1'b1;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);                                              // R7
   AST_DONE_NEEDS_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> chk_busy);                                             // R8
   AST_MIN_WAIT: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (chk_cnt > chk_wait));                                 // R5
   AST_IGN_EXACT: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && chk_ign) |-> (chk_cnt == chk_wait + 1'b1));            // R4
   AST_READY_SEEN: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && !chk_ign) |-> ($past(srdy_i) || $past(ardy_q_i)));     // R3
endmodule

bind bus_ready_term brt_checker #(.WAIT_W(WAIT_W)) u_brt_checker (
   .clk_i     (clk_i),
   .rst_i     (rst_i),
   .srdy_i    (srdy_i),
   .ardy_q_i  (ardy_q),
   .start_i   (start_i),
   .ign_rdy_i (ign_rdy_i),
   .wait_cnt_i(wait_cnt_i),
   .done_o    (done_o)
);

// File: tb/test_bus_ready_term.sv
`timescale 1ns/1ps
module test_bus_ready_term;
   localparam int WAIT_W = 2;
   localparam int NVEC   = 12;
   // vector: ign(1) wait(2) src(2: 0 none,1 sync,2 async,3 both) dly(4) exp(5)
   localparam logic [13:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 2'd1, 4'd0, 5'd1},
      {1'b0, 2'd2, 2'd1, 4'd0, 5'd3},
      {1'b0, 2'd0, 2'd1, 4'd4, 5'd5},
      {1'b0, 2'd3, 2'd1, 4'd1, 5'd4},
      {1'b0, 2'd0, 2'd2, 4'd0, 5'd2},
      {1'b0, 2'd3, 2'd2, 4'd0, 5'd4},
      {1'b0, 2'd1, 2'd2, 4'd5, 5'd7},
      {1'b1, 2'd0, 2'd0, 4'd0, 5'd1},
      {1'b1, 2'd3, 2'd0, 4'd0, 5'd4},
      {1'b1, 2'd2, 2'd1, 4'd0, 5'd3},
      {1'b0, 2'd1, 2'd3, 4'd3, 5'd4},
      {1'b0, 2'd2, 2'd3, 4'd0, 5'd3}
   };

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              ardy = 1'b0;
   logic              srdy = 1'b0;
   logic              start = 1'b0;
   logic              ign = 1'b0;
   logic [WAIT_W-1:0] wcnt = '0;
   logic              done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bus_ready_term #(.WAIT_W(WAIT_W)) i_bus_ready_term (
      .clk_i     (clk),
      .rst_i     (rst),
      .ardy_i    (ardy),
      .srdy_i    (srdy),
      .start_i   (start),
      .ign_rdy_i (ign),
      .wait_cnt_i(wcnt),
      .done_o    (done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // start a cycle: strobe sampled on the next edge (E0), back to 0 after it
   task automatic open_cycle(input bit i, input int w);
      start = 1'b1; ign = i; wcnt = WAIT_W'(w);
      step();
      start = 1'b0;
   endtask

   task automatic idle(input int n);
      srdy = 1'b0; ardy = 1'b0;
      for (int i = 0; i < n; i++) step();
   endtask

   // count done pulses over n edges
   task automatic count_done(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (done) c++;
      end
   endtask

   initial begin
      int c;
      int seen;
      step(); step();
      check(done == 1'b0, "R9 reset state", done, 0);
      rst = 1'b0;
      step();
      check(done == 1'b0, "R9 after reset", done, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         automatic bit i_f = VEC[v][13];
         automatic int w   = VEC[v][12:11];
         automatic int src = VEC[v][10:9];
         automatic int d   = VEC[v][8:5];
         automatic int ex  = VEC[v][4:0];
         open_cycle(i_f, w);
         seen = 0;
         if (d == 0) begin
            srdy = src[0]; ardy = src[1];
         end
         for (int k = 1; k <= 20 && seen == 0; k++) begin
            step();
            if (done) seen = k;
            if (k == d) begin
               srdy = src[0]; ardy = src[1];
            end
         end
         check(seen == ex, $sformatf("R1 R2 R3 R4 R5 vector %0d done edge", v), seen, ex);
         step();
         check(done == 1'b0, $sformatf("R7 vector %0d pulse width", v), done, 0);
         idle(3);
      end

      // R6: no ready, cycle stretches
      open_cycle(1'b0, 0);
      count_done(10, c);
      check(c == 0, "R6 no done without ready", c, 0);
      srdy = 1'b1;
      step();
      check(done == 1'b1, "R6 done after late ready", done, 1);
      idle(3);

      // R4: ignore mode with both ready lines high still waits the full count
      srdy = 1'b1; ardy = 1'b1;
      open_cycle(1'b1, 3);
      seen = 0;
      for (int k = 1; k <= 8 && seen == 0; k++) begin
         step();
         if (done) seen = k;
      end
      check(seen == 4, "R4 ready ignored in ignore mode", seen, 4);
      idle(3);

      // R10: config changed during the cycle has no effect
      open_cycle(1'b1, 3);
      ign = 1'b0; wcnt = '0;
      seen = 0;
      for (int k = 1; k <= 8 && seen == 0; k++) begin
         step();
         if (done) seen = k;
      end
      check(seen == 4, "R10 config latched at start", seen, 4);
      idle(3);

      // R8: second start during a cycle is ignored
      open_cycle(1'b1, 2);
      step();
      start = 1'b1;
      step();
      start = 1'b0;
      seen = 0;
      c = 0;
      for (int k = 3; k <= 10; k++) begin
         step();
         if (done) begin
            c++;
            if (seen == 0) seen = k;
         end
      end
      check(seen == 3, "R8 first done unchanged", seen, 3);
      check(c == 1, "R8 single done pulse", c, 1);
      idle(3);

      // R9: reset in the middle of a cycle
      open_cycle(1'b0, 0);
      step(); step();
      rst = 1'b1;
      step(); step();
      check(done == 1'b0, "R9 done low in reset", done, 0);
      rst = 1'b0;
      srdy = 1'b1;
      count_done(6, c);
      check(c == 0, "R9 cycle cleared by reset", c, 0);
      idle(3);

      // R2: async alone after reset works with one extra edge
      open_cycle(1'b0, 0);
      ardy = 1'b1;
      step();
      check(done == 1'b0, "R2 not yet after first edge", done, 0);
      step();
      check(done == 1'b1, "R2 done on second edge", done, 1);
      idle(3);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule